// File: doc/BRIEF.md
# Eight-Drive Register Bank with Function Decode

This block holds the per-drive register state for a group of disk drives that sit behind one controller. Each drive has a control word (function code plus GO), a packed status word, a 16-bit error word, a desired sector/track word and a fixed read-only type code. One further word, shared by all drives, reports and clears every drive's attention flag. A host-side decoder (not part of this block) issues one access per cycle, addressed by drive number and register number. Reads return data one cycle later. Writes update state at the clock edge.

Writing a function to a ready drive with GO set is decoded at once. A seek or data-transfer function marks the drive busy and emits a one-cycle start pulse to the transfer sequencer. The sequencer later returns a completion pulse for that drive. Preset, drive clear, no-op and unknown codes complete in the same edge. A sticky attention flag per drive is raised by finished searches, faults and unknown codes. The OR of all attention flags drives a single controller attention level.

Top module: `drvreg_bank`

## Requirements
- R1: After reset every drive reads ready, with control word, error word and desired address all zero, no attention, no position-in-progress. `attn_any`, `rd_valid`, `start_pulse` and `reject_pulse` are low.
- R2: A read presented in one cycle returns `rd_valid` high with `rd_data` in the next cycle. Register numbers: 0 control, 1 status, 2 error, 3 zero, 4 attention summary, 5 desired address, 6 type, 7 zero. A desired-address write is read back unchanged.
- R3: A control write (register 0) with bit 0 (GO) set to a ready drive, with function field bits 5:1 equal to octal 014, 024, 030 or 034, gives the following in the next cycle: `start_pulse` high for one cycle, with `start_drive` and `start_func` naming the request. The drive then reads not-ready with position-in-progress set, and its control word reads the function with GO = 1.
- R4: A GO control write to a drive that is not ready changes no state of that drive and raises `reject_pulse` in the next cycle with no start. A control write with GO = 0 has no effect.
- R5: Preset (field octal 010) zeroes the desired address, sets volume-valid to the drive's online input and leaves the drive ready. No-op (field 0) changes only the stored function field.
- R6: Drive clear (field octal 004) leaves the drive ready and clears its attention and GO. `attn_any` then reflects only the remaining drives.
- R7: Any other function field with GO on a ready drive keeps the drive ready, sets its attention and sets error-word bit 0.
- R8: A completion pulse for a drive with an operation pending clears GO and position-in-progress and sets ready. It sets attention if the pending function was search (octal 014). With `done_fault` it also sets attention and error-word bit 10. A completion for a drive with nothing pending is ignored.
- R9: Register 4 reads one bit per drive (bit n = drive n attention). Writing register 4 clears attention on each drive whose data bit is 1. An attention raised by a completion in the same cycle wins over the clear. `attn_any` is the OR of all attention flags.
- R10: Writing register 2 stores the 16-bit value. Status bit 14 (error) reads 1 exactly when the error word is nonzero.
- R11: Any read or write of register numbers 8 to 31 sets error-word bit 1, and such a read returns 0. Writes to registers 1, 3, 6 and 7 change nothing.
- R12: Status layout: bit 6 volume-valid, 7 ready, 8 present (= online), 10 last sector (always 0), 11 write-locked (= wlock input), 12 online, 13 position-in-progress, 14 error, 15 attention. Register 6 returns the drive's slice of `DRV_TYPES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_drive | input | DRV_W | Addressed drive |
| acc_reg | input | 5 | Register number |
| acc_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after read) |
| rd_data | output | 16 | Read data |
| drv_online | input | NUM_DRV | Medium online per drive |
| drv_wlock | input | NUM_DRV | Write lock per drive |
| start_pulse | output | 1 | Start request to transfer sequencer |
| start_drive | output | DRV_W | Drive to start |
| start_func | output | 5 | Function to start |
| reject_pulse | output | 1 | GO refused because drive busy |
| done_valid | input | 1 | Completion from transfer sequencer |
| done_drive | input | DRV_W | Drive that completed |
| done_fault | input | 1 | Completion ended with address fault |
| attn_any | output | 1 | OR of all drive attention flags |

## Verification
Two events can hit one drive's attention flag in the same cycle: a completion that raises it, and a summary-register write that clears it. The bench provokes this by starting a search on one drive, then presenting that drive's completion and an all-ones summary write on the same edge. It judges the result by reading the summary word and `attn_any`, which must still show the flag set. A second overlap sends a completion to one drive while another drive is cleared. The bench checks that each drive ends in its own expected state.

// File: rtl/drvreg_pkg.sv
package drvreg_pkg;

  localparam int WORD_W = 16;
  localparam int FUNC_W = 5;
  localparam int RNUM_W = 5;

  // status bit positions (decoded by the host side)
  localparam int ST_VV  = 6;
  localparam int ST_RDY = 7;
  localparam int ST_PRS = 8;
  localparam int ST_LST = 10;
  localparam int ST_WRL = 11;
  localparam int ST_MOL = 12;
  localparam int ST_PIP = 13;
  localparam int ST_ERR = 14;
  localparam int ST_ATA = 15;

  // error word bit positions
  localparam int EB_ILLFN  = 0;
  localparam int EB_ILLREG = 1;
  localparam int EB_ADDR   = 10;

  typedef enum logic [2:0] {
    FK_NOP, FK_CLEAR, FK_PRESET, FK_SEARCH, FK_XFER, FK_BAD
  } fkind_e;

  typedef enum logic [2:0] {
    RC_CTL, RC_STAT, RC_ERR, RC_ZERO, RC_SUM, RC_ADDR, RC_TYPE, RC_BAD
  } rclass_e;

  function automatic fkind_e decode_func(input logic [FUNC_W-1:0] fc);
    case (fc)
      5'o00:               return FK_NOP;
      5'o04:               return FK_CLEAR;
      5'o10:               return FK_PRESET;
      5'o14:               return FK_SEARCH;
      5'o24, 5'o30, 5'o34: return FK_XFER;
      default:             return FK_BAD;
    endcase
  endfunction

  function automatic rclass_e classify_reg(input logic [RNUM_W-1:0] r);
    case (r)
      5'd0:       return RC_CTL;
      5'd1:       return RC_STAT;
      5'd2:       return RC_ERR;
      5'd3, 5'd7: return RC_ZERO;
      5'd4:       return RC_SUM;
      5'd5:       return RC_ADDR;
      5'd6:       return RC_TYPE;
      default:    return RC_BAD;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(
    input logic vv, input logic rdy, input logic online, input logic wlock,
    input logic pip, input logic err, input logic ata);
    logic [WORD_W-1:0] s;
    s         = '0;
    s[ST_VV]  = vv;
    s[ST_RDY] = rdy;
    s[ST_PRS] = online;
    s[ST_LST] = 1'b0;
    s[ST_WRL] = wlock;
    s[ST_MOL] = online;
    s[ST_PIP] = pip;
    s[ST_ERR] = err;
    s[ST_ATA] = ata;
    return s;
  endfunction

  function automatic logic [WORD_W-1:0] pack_ctl(
    input logic [FUNC_W-1:0] fc, input logic go);
    return {{(WORD_W-FUNC_W-1){1'b0}}, fc, go};
  endfunction

endpackage

// File: rtl/drvreg_decode.sv
module drvreg_decode
  import drvreg_pkg::*;
#(
  parameter int NUM_DRV = 8,
  localparam int DRV_W = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [DRV_W-1:0]   acc_drive,
  input  logic [RNUM_W-1:0]  acc_reg,
  output logic [NUM_DRV-1:0] wr_ctl_v,
  output logic [NUM_DRV-1:0] wr_err_v,
  output logic [NUM_DRV-1:0] wr_addr_v,
  output logic [NUM_DRV-1:0] bad_v,
  output logic               sum_wr,
  output logic               rd_fire
);

  rclass_e rc;
  logic    wr_fire;

  always_comb begin
    rc      = classify_reg(acc_reg);
    wr_fire = acc_valid & acc_write;
    rd_fire = acc_valid & ~acc_write;
    sum_wr  = wr_fire & (rc == RC_SUM);
  end

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_sel
    logic hit;
    assign hit          = acc_valid & (acc_drive == DRV_W'(d));
    assign wr_ctl_v[d]  = hit & acc_write & (rc == RC_CTL);
    assign wr_err_v[d]  = hit & acc_write & (rc == RC_ERR);
    assign wr_addr_v[d] = hit & acc_write & (rc == RC_ADDR);
    assign bad_v[d]     = hit & (rc == RC_BAD);
  end

endmodule

// File: rtl/drvreg_unit.sv
module drvreg_unit
  import drvreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_err,
  input  logic              wr_addr,
  input  logic              acc_bad,
  input  logic              sum_clr,
  input  logic              done_in,
  input  logic              done_fault,
  input  logic              online,
  input  logic [WORD_W-1:0] wdata,
  output logic [FUNC_W-1:0] func_q,
  output logic              go_q,
  output logic              rdy_q,
  output logic              pip_q,
  output logic              vv_q,
  output logic              ata_q,
  output logic [WORD_W-1:0] err_q,
  output logic [WORD_W-1:0] da_q,
  output logic              start_ev,
  output logic              reject_ev
);

  fkind_e            kind;
  logic              go_cmd, act, finish;
  logic              ata_n;
  logic [WORD_W-1:0] err_n;

  always_comb begin
    kind      = decode_func(wdata[FUNC_W:1]);
    go_cmd    = wr_ctl & wdata[0];
    act       = go_cmd & rdy_q;
    reject_ev = go_cmd & ~rdy_q;
    start_ev  = act & ((kind == FK_SEARCH) || (kind == FK_XFER));
    finish    = done_in & go_q;

    // attention: clears first, then sets, so a raise in the same cycle wins
    ata_n = ata_q;
    if (sum_clr) ata_n = 1'b0;
    if (act && kind == FK_CLEAR) ata_n = 1'b0;
    if (act && kind == FK_BAD) ata_n = 1'b1;
    if (finish && ((func_q == 5'o14) || done_fault)) ata_n = 1'b1;

    err_n = err_q;
    if (wr_err) err_n = wdata;
    if (acc_bad) err_n[EB_ILLREG] = 1'b1;
    if (act && kind == FK_BAD) err_n[EB_ILLFN] = 1'b1;
    if (finish && done_fault) err_n[EB_ADDR] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      func_q <= '0;
      go_q   <= 1'b0;
      rdy_q  <= 1'b1;
      pip_q  <= 1'b0;
      vv_q   <= 1'b0;
      ata_q  <= 1'b0;
      err_q  <= '0;
      da_q   <= '0;
    end else begin
      ata_q <= ata_n;
      err_q <= err_n;
      if (wr_addr) da_q <= wdata;
      if (finish) begin
        go_q  <= 1'b0;
        pip_q <= 1'b0;
        rdy_q <= 1'b1;
      end
      if (act) begin
        func_q <= wdata[FUNC_W:1];
        case (kind)
          FK_CLEAR:  go_q <= 1'b0;
          FK_PRESET: begin
            da_q <= '0;
            vv_q <= online;
          end
          FK_SEARCH, FK_XFER: begin
            go_q  <= 1'b1;
            pip_q <= 1'b1;
            rdy_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/drvreg_rdmux.sv
module drvreg_rdmux
  import drvreg_pkg::*;
#(
  parameter int NUM_DRV = 8,
  parameter logic [NUM_DRV*WORD_W-1:0] TYPES = '0,
  localparam int DRV_W = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  logic [DRV_W-1:0]               rd_drive,
  input  logic [RNUM_W-1:0]              rd_reg,
  input  logic [NUM_DRV-1:0][FUNC_W-1:0] func_arr,
  input  logic [NUM_DRV-1:0]             go_vec,
  input  logic [NUM_DRV-1:0][WORD_W-1:0] stat_arr,
  input  logic [NUM_DRV-1:0][WORD_W-1:0] err_arr,
  input  logic [NUM_DRV-1:0][WORD_W-1:0] da_arr,
  input  logic [NUM_DRV-1:0]             ata_vec,
  output logic [WORD_W-1:0]              rdata
);

  logic [WORD_W-1:0] sum_word;
  logic              drv_ok;

  always_comb begin
    sum_word              = '0;
    sum_word[NUM_DRV-1:0] = ata_vec;
    drv_ok                = (32'(rd_drive) < NUM_DRV);
    rdata                 = '0;
    if (drv_ok) begin
      case (classify_reg(rd_reg))
        RC_CTL:  rdata = pack_ctl(func_arr[rd_drive], go_vec[rd_drive]);
        RC_STAT: rdata = stat_arr[rd_drive];
        RC_ERR:  rdata = err_arr[rd_drive];
        RC_SUM:  rdata = sum_word;
        RC_ADDR: rdata = da_arr[rd_drive];
        RC_TYPE: rdata = TYPES[rd_drive*WORD_W +: WORD_W];
        default: rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/drvreg_bank.sv
module drvreg_bank
  import drvreg_pkg::*;
#(
  parameter int NUM_DRV = 8,
  parameter logic [NUM_DRV*WORD_W-1:0] DRV_TYPES = {{4{16'o20003}}, {4{16'o20002}}},
  localparam int DRV_W = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [DRV_W-1:0]   acc_drive,
  input  logic [RNUM_W-1:0]  acc_reg,
  input  logic [WORD_W-1:0]  acc_wdata,
  output logic               rd_valid,
  output logic [WORD_W-1:0]  rd_data,
  input  logic [NUM_DRV-1:0] drv_online,
  input  logic [NUM_DRV-1:0] drv_wlock,
  output logic               start_pulse,
  output logic [DRV_W-1:0]   start_drive,
  output logic [FUNC_W-1:0]  start_func,
  output logic               reject_pulse,
  input  logic               done_valid,
  input  logic [DRV_W-1:0]   done_drive,
  input  logic               done_fault,
  output logic               attn_any
);

  logic [NUM_DRV-1:0] wr_ctl_v, wr_err_v, wr_addr_v, bad_v;
  logic               sum_wr, rd_fire;
  logic [NUM_DRV-1:0] sum_clr_v, done_sel_v;
  logic [NUM_DRV-1:0] go_vec, rdy_vec, pip_vec, vv_vec, ata_vec, errnz_vec;
  logic [NUM_DRV-1:0] start_ev_v, reject_ev_v;
  logic [NUM_DRV-1:0][FUNC_W-1:0] func_arr;
  logic [NUM_DRV-1:0][WORD_W-1:0] err_arr, da_arr, stat_arr;
  logic [WORD_W-1:0]  rd_mux;

  drvreg_decode #(.NUM_DRV(NUM_DRV)) u_dec (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_drive (acc_drive),
    .acc_reg   (acc_reg),
    .wr_ctl_v  (wr_ctl_v),
    .wr_err_v  (wr_err_v),
    .wr_addr_v (wr_addr_v),
    .bad_v     (bad_v),
    .sum_wr    (sum_wr),
    .rd_fire   (rd_fire)
  );

  assign sum_clr_v = sum_wr ? acc_wdata[NUM_DRV-1:0] : '0;

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    assign done_sel_v[d] = done_valid & (done_drive == DRV_W'(d));

    drvreg_unit u_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctl     (wr_ctl_v[d]),
      .wr_err     (wr_err_v[d]),
      .wr_addr    (wr_addr_v[d]),
      .acc_bad    (bad_v[d]),
      .sum_clr    (sum_clr_v[d]),
      .done_in    (done_sel_v[d]),
      .done_fault (done_fault),
      .online     (drv_online[d]),
      .wdata      (acc_wdata),
      .func_q     (func_arr[d]),
      .go_q       (go_vec[d]),
      .rdy_q      (rdy_vec[d]),
      .pip_q      (pip_vec[d]),
      .vv_q       (vv_vec[d]),
      .ata_q      (ata_vec[d]),
      .err_q      (err_arr[d]),
      .da_q       (da_arr[d]),
      .start_ev   (start_ev_v[d]),
      .reject_ev  (reject_ev_v[d])
    );

    assign errnz_vec[d] = |err_arr[d];
    assign stat_arr[d]  = pack_status(vv_vec[d], rdy_vec[d], drv_online[d],
                                      drv_wlock[d], pip_vec[d], errnz_vec[d],
                                      ata_vec[d]);
  end

  drvreg_rdmux #(.NUM_DRV(NUM_DRV), .TYPES(DRV_TYPES)) u_rdmux (
    .rd_drive (acc_drive),
    .rd_reg   (acc_reg),
    .func_arr (func_arr),
    .go_vec   (go_vec),
    .stat_arr (stat_arr),
    .err_arr  (err_arr),
    .da_arr   (da_arr),
    .ata_vec  (ata_vec),
    .rdata    (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      start_pulse  <= 1'b0;
      start_drive  <= '0;
      start_func   <= '0;
      reject_pulse <= 1'b0;
    end else begin
      rd_valid     <= rd_fire;
      if (rd_fire) rd_data <= rd_mux;
      start_pulse  <= |start_ev_v;
      reject_pulse <= |reject_ev_v;
      if (|start_ev_v) begin
        start_drive <= acc_drive;
        start_func  <= acc_wdata[FUNC_W:1];
      end
    end
  end

  assign attn_any = |ata_vec;

endmodule

// File: rtl/drvreg_chk.sv
module drvreg_chk
  import drvreg_pkg::*;
#(
  parameter int NUM_DRV = 8,
  localparam int DRV_W = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               acc_write,
  input logic [DRV_W-1:0]   acc_drive,
  input logic [RNUM_W-1:0]  acc_reg,
  input logic [WORD_W-1:0]  acc_wdata,
  input logic               rd_valid,
  input logic               start_pulse,
  input logic [DRV_W-1:0]   start_drive,
  input logic               reject_pulse,
  input logic               done_valid,
  input logic [DRV_W-1:0]   done_drive,
  input logic               attn_any,
  input logic [NUM_DRV-1:0] rdy_vec,
  input logic [NUM_DRV-1:0] pip_vec,
  input logic [NUM_DRV-1:0] ata_vec,
  input logic [NUM_DRV-1:0] errnz_vec
);

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid); // R2

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (pip_vec[start_drive] && !rdy_vec[start_drive])); // R3

  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_reg == 5'd0 && acc_wdata[0] && !rdy_vec[acc_drive])
    |=> (reject_pulse && !start_pulse)); // R4

  AST_ILLFN_ATTN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_reg == 5'd0 && acc_wdata[0] && rdy_vec[acc_drive] &&
     !(acc_wdata[5:1] inside {5'o00, 5'o04, 5'o10, 5'o14, 5'o24, 5'o30, 5'o34}))
    |=> (ata_vec[$past(acc_drive)] && errnz_vec[$past(acc_drive)])); // R7

  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && pip_vec[done_drive])
    |=> (rdy_vec[$past(done_drive)] && !pip_vec[$past(done_drive)])); // R8

  AST_SUMMARY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_reg == 5'd4 && (&acc_wdata[NUM_DRV-1:0]) && !done_valid)
    |=> !attn_any); // R9

  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_reg == 5'd2 && acc_wdata != '0)
    |=> errnz_vec[$past(acc_drive)]); // R10

  AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && reject_pulse)); // R4

endmodule

bind drvreg_bank drvreg_chk #(.NUM_DRV(NUM_DRV)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid    (acc_valid),
  .acc_write    (acc_write),
  .acc_drive    (acc_drive),
  .acc_reg      (acc_reg),
  .acc_wdata    (acc_wdata),
  .rd_valid     (rd_valid),
  .start_pulse  (start_pulse),
  .start_drive  (start_drive),
  .reject_pulse (reject_pulse),
  .done_valid   (done_valid),
  .done_drive   (done_drive),
  .attn_any     (attn_any),
  .rdy_vec      (rdy_vec),
  .pip_vec      (pip_vec),
  .ata_vec      (ata_vec),
  .errnz_vec    (errnz_vec)
);

// File: tb/tb_drvreg_bank.sv
`timescale 1ns/1ps
module tb_drvreg_bank;

  localparam int N = 8;

  function automatic logic [N*16-1:0] mk_types();
    logic [N*16-1:0] t;
    for (int d = 0; d < N; d++) t[d*16 +: 16] = 16'o20000 + 16'(d * 5 + 1);
    return t;
  endfunction
  localparam logic [N*16-1:0] TB_TYPES = mk_types();

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [2:0]  acc_drive = '0;
  logic [4:0]  acc_reg = '0;
  logic [15:0] acc_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [N-1:0] drv_online = 8'b1010_0111;
  logic [N-1:0] drv_wlock  = 8'b0101_0011;
  logic        start_pulse, reject_pulse, attn_any;
  logic [2:0]  start_drive;
  logic [4:0]  start_func;
  logic        done_valid = 1'b0, done_fault = 1'b0;
  logic [2:0]  done_drive = '0;

  drvreg_bank #(.NUM_DRV(N), .DRV_TYPES(TB_TYPES)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_drive(acc_drive), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .drv_online(drv_online),
    .drv_wlock(drv_wlock), .start_pulse(start_pulse), .start_drive(start_drive),
    .start_func(start_func), .reject_pulse(reject_pulse), .done_valid(done_valid),
    .done_drive(done_drive), .done_fault(done_fault), .attn_any(attn_any)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // expected model built from the requirements
  logic [4:0]  m_func [N];
  logic        m_go [N], m_rdy [N], m_pip [N], m_vv [N], m_ata [N];
  logic [15:0] m_err [N], m_da [N];

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_status(input int d);
    logic [15:0] s = '0;
    s[6] = m_vv[d]; s[7] = m_rdy[d]; s[8] = drv_online[d]; s[11] = drv_wlock[d];
    s[12] = drv_online[d]; s[13] = m_pip[d]; s[14] = (m_err[d] != 0); s[15] = m_ata[d];
    return s;
  endfunction

  function automatic logic [15:0] exp_sum();
    logic [15:0] s = '0;
    for (int d = 0; d < N; d++) s[d] = m_ata[d];
    return s;
  endfunction

  function automatic bit is_xfer(input logic [4:0] f);
    return (f == 5'o14) || (f == 5'o24) || (f == 5'o30) || (f == 5'o34);
  endfunction

  task automatic model_reset();
    for (int d = 0; d < N; d++) begin
      m_func[d] = 0; m_go[d] = 0; m_rdy[d] = 1; m_pip[d] = 0; m_vv[d] = 0;
      m_ata[d] = 0; m_err[d] = 0; m_da[d] = 0;
    end
  endtask

  task automatic wr(input int d, input int r, input logic [15:0] v, input string req);
    bit e_start = 0, e_rej = 0;
    if (r == 0 && v[0]) begin
      if (!m_rdy[d]) e_rej = 1;
      else begin
        m_func[d] = v[5:1];
        case (v[5:1])
          5'o00: ;
          5'o04: begin m_ata[d] = 0; m_go[d] = 0; end
          5'o10: begin m_da[d] = 0; m_vv[d] = drv_online[d]; end
          5'o14, 5'o24, 5'o30, 5'o34: begin
            m_go[d] = 1; m_pip[d] = 1; m_rdy[d] = 0; e_start = 1;
          end
          default: begin m_ata[d] = 1; m_err[d][0] = 1; end
        endcase
      end
    end else if (r == 2) m_err[d] = v;
    else if (r == 4) begin
      for (int k = 0; k < N; k++) if (v[k]) m_ata[k] = 0;
    end else if (r == 5) m_da[d] = v;
    else if (r >= 8) m_err[d][1] = 1;
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_drive = d[2:0]; acc_reg = r[4:0]; acc_wdata = v;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    chk(req, "start_pulse", start_pulse, e_start);
    chk(req, "reject_pulse", reject_pulse, e_rej);
    if (e_start) begin
      chk(req, "start_drive", start_drive, d);
      chk(req, "start_func", start_func, v[5:1]);
    end
  endtask

  task automatic rd(input int d, input int r, output logic [15:0] v);
    if (r >= 8) m_err[d][1] = 1;
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_drive = d[2:0]; acc_reg = r[4:0];
    @(negedge clk);
    acc_valid = 0;
    chk("R2", "rd_valid", rd_valid, 1);
    v = rd_data;
  endtask

  task automatic done(input int d, input bit fault);
    if (m_go[d]) begin
      if (m_func[d] == 5'o14 || fault) m_ata[d] = 1;
      if (fault) m_err[d][10] = 1;
      m_go[d] = 0; m_pip[d] = 0; m_rdy[d] = 1;
    end
    @(negedge clk);
    done_valid = 1; done_drive = d[2:0]; done_fault = fault;
    @(negedge clk);
    done_valid = 0; done_fault = 0;
  endtask

  task automatic chk_drive(input int d, input string req);
    logic [15:0] v;
    rd(d, 1, v); chk(req, $sformatf("status d%0d", d), v, exp_status(d));
    rd(d, 0, v); chk(req, $sformatf("control d%0d", d), v, {10'd0, m_func[d], m_go[d]});
    rd(d, 2, v); chk(req, $sformatf("error d%0d", d), v, m_err[d]);
    rd(d, 5, v); chk(req, $sformatf("address d%0d", d), v, m_da[d]);
    rd(d, 4, v); chk("R9", "summary", v, exp_sum());
    chk("R9", "attn_any", attn_any, |exp_sum());
  endtask

  function automatic string req_of(input logic [4:0] f);
    case (f)
      5'o00, 5'o10: return "R5";
      5'o04:        return "R6";
      5'o14, 5'o24, 5'o30, 5'o34: return "R3";
      default:      return "R7";
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rd_valid", rd_valid, 0);
    chk("R1", "attn_any", attn_any, 0);
    chk("R1", "start_pulse", start_pulse, 0);
    chk("R1", "reject_pulse", reject_pulse, 0);
    for (int d = 0; d < N; d++) chk_drive(d, "R1");

    // R12 type codes and layout
    for (int d = 0; d < N; d++) begin
      rd(d, 6, v); chk("R12", $sformatf("type d%0d", d), v, 16'o20000 + 16'(d * 5 + 1));
    end

    // R2 address register sweep
    for (int d = 0; d < N; d++) begin
      wr(d, 5, 16'h1234 ^ 16'(d * 16'h1111), "R2");
      rd(d, 5, v); chk("R2", "address readback", v, m_da[d]);
    end

    // R11 ignored writes and undefined registers
    for (int d = 0; d < N; d++) begin
      wr(d, 1, 16'hffff, "R11"); wr(d, 3, 16'hffff, "R11");
      wr(d, 6, 16'h0000, "R11"); wr(d, 7, 16'hffff, "R11");
      rd(d, 3, v); chk("R11", "reg3", v, 0);
      rd(d, 7, v); chk("R11", "reg7", v, 0);
      rd(d, 6, v); chk("R11", "type kept", v, 16'o20000 + 16'(d * 5 + 1));
      chk_drive(d, "R11");
    end
    for (int r = 8; r < 32; r++) begin
      rd(6, r, v); chk("R11", $sformatf("undefined read %0d", r), v, 0);
      rd(6, 2, v); chk("R11", "illegal-register bit", v, m_err[6]);
      wr(6, 2, 16'h0000, "R10");
      wr(6, r, 16'hbeef, "R11");
      rd(6, 2, v); chk("R11", "illegal-register bit on write", v, 16'h0002);
      wr(6, 2, 16'h0000, "R10");
    end

    // R10 error word and status error bit
    for (int d = 0; d < N; d++) begin
      wr(d, 2, 16'h8000 >> d, "R10"); chk_drive(d, "R10");
      wr(d, 2, 16'h0000, "R10"); chk_drive(d, "R10");
    end

    // main sweep: every drive, every function code
    for (int d = 0; d < N; d++) begin
      for (int f = 0; f < 32; f++) begin
        logic [4:0] fc = f[4:0];
        wr(d, 5, 16'h0a5a ^ 16'(d * 32 + f), "R2");
        wr(d, 0, {10'd0, fc, 1'b0}, "R4");
        chk_drive(d, "R4");
        wr(d, 0, {10'd0, fc, 1'b1}, req_of(fc));
        chk_drive(d, req_of(fc));
        if (is_xfer(fc)) begin
          wr(d, 0, {10'd0, 5'o04, 1'b1}, "R4");
          chk_drive(d, "R4");
          done(d, (fc == 5'o34) && d[0]);
          chk_drive(d, "R8");
          done(d, 1'b1);
          chk_drive(d, "R8");
        end
        wr(d, 4, 16'h00ff, "R9");
        wr(d, 2, 16'h0000, "R10");
        chk_drive(d, "R9");
      end
    end

    // R6 drive clear with attention on another drive
    wr(2, 0, {10'd0, 5'o37, 1'b1}, "R7");
    wr(5, 0, {10'd0, 5'o21, 1'b1}, "R7");
    wr(2, 0, {10'd0, 5'o04, 1'b1}, "R6");
    chk_drive(2, "R6");
    chk("R6", "attn_any other drive", attn_any, 1);
    wr(5, 0, {10'd0, 5'o04, 1'b1}, "R6");
    chk("R6", "attn_any none", attn_any, 0);

    // R9 collision: completion raises attention while summary write clears it
    wr(1, 0, {10'd0, 5'o14, 1'b1}, "R3");
    wr(4, 0, {10'd0, 5'o30, 1'b1}, "R3");
    m_ata[1] = 1; m_go[1] = 0; m_pip[1] = 0; m_rdy[1] = 1;
    @(negedge clk);
    done_valid = 1; done_drive = 3'd1; done_fault = 0;
    acc_valid = 1; acc_write = 1; acc_drive = 3'd4; acc_reg = 5'd4; acc_wdata = 16'h00ff;
    @(negedge clk);
    done_valid = 0; acc_valid = 0; acc_write = 0;
    chk("R9", "raise wins over clear", attn_any, 1);
    chk_drive(1, "R9");
    chk_drive(4, "R8");
    done(4, 1'b0);
    chk_drive(4, "R8");
    // R8 completion with nothing pending is ignored
    done(4, 1'b1);
    chk_drive(4, "R8");

    finished = 1;
    summary();
    $finish;
  end

endmodule